// File: doc/BRIEF.md
# Write-Through Single-Word Write Buffer

This block sits between the data-write port of a processor and a slower external memory, inside a cache that only writes through. Every processor write is sent to external memory. A hit/miss input decides whether the cache data array is written in the same cycle as well, and whether the replacement-order state is told to update. Misses never touch the cache array and never start a line fill.

The forward path to memory has two settings, chosen by a configuration bit that resets to 1. When the bit is 1, the write is posted into a one-word holding slot and the processor goes on at once. The slot then drains to a request/acknowledge port on its own. When the bit is 0, the write goes straight to the port and the processor is held until the memory acknowledges.

Two status flags report progress. One shows that the slot is free. The other shows that the last external write has actually completed.

Top module: `wt_wbuf`

## Requirements
- R1: After reset, both status flags read 1, no external request is raised, the processor is not stalled, and buffered operation is selected.
- R2: A write accepted with `cpu_hit`=1 raises `cache_we` and `lru_upd` for exactly that cycle. In that cycle, `cache_addr`, `cache_wdata` and `cache_be` equal the processor's address, data and byte enables.
- R3: A write accepted with `cpu_hit`=0 leaves `cache_we` and `lru_upd` at 0, and the word is still written to external memory.
- R4: In buffered mode, a write that finds the slot free is accepted in the same cycle with no stall. `flag_empty` reads 0 from the following cycle.
- R5: A held word moves to the external port at the first clock edge at which no request is outstanding. At that same edge `ext_req` rises, `flag_empty` returns to 1 and `flag_done` falls to 0.
- R6: At the clock edge where `ext_req` and `ext_ack` are both 1, `ext_req` drops and `flag_done` returns to 1. `flag_done` rises at no other time.
- R7: While `ext_req` is 1 and not yet acknowledged, `ext_req`, `ext_addr`, `ext_wdata` and `ext_be` hold their values.
- R8: In buffered mode, a write that arrives while the slot is full is stalled until the slot has drained. A write issued in the cycle right after a write into an empty slot, with the port idle, is stalled for exactly one cycle.
- R9: With the enable bit at 0, a write is stalled until its own external acknowledge. It is accepted in the acknowledge cycle, its data is in memory when the stall ends, and `flag_empty` stays 1 throughout.
- R10: A cycle with `cfg_we`=1 loads `cfg_en_d` into the enable bit, and operation follows the new setting from the next write on.
- R11: External memory receives only the byte lanes whose `ext_be` bit is 1, where bit k covers data bits 8k+7..8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the enable bit |
| cfg_en_d | input | 1 | New enable value: 1 buffered, 0 direct |
| cpu_wr_req | input | 1 | Processor write request, held while stalled |
| cpu_addr | input | ADDR_W | Write address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_be | input | DATA_W/8 | Byte enables |
| cpu_hit | input | 1 | Tag lookup result for this write |
| cpu_stall | output | 1 | Processor must hold its request |
| cache_we | output | 1 | Cache data array write strobe |
| cache_addr | output | ADDR_W | Cache write address |
| cache_wdata | output | DATA_W | Cache write data |
| cache_be | output | DATA_W/8 | Cache byte enables |
| lru_upd | output | 1 | Replacement-order update strobe |
| ext_req | output | 1 | External write request |
| ext_addr | output | ADDR_W | External write address |
| ext_wdata | output | DATA_W | External write data |
| ext_be | output | DATA_W/8 | External byte enables |
| ext_ack | input | 1 | External write acknowledge |
| flag_empty | output | 1 | Holding slot is free |
| flag_done | output | 1 | Last external write has completed |

## Verification
The hardest state to reach is a slot that is full while an earlier word is still waiting on the external port. Only then does the stall depend on the memory's acknowledge delay and not just on the drain edge. The bench gets there by issuing three writes back to back, each in the first cycle the previous one is accepted. The memory model stretches each acknowledge by a random zero to three cycles. The direct setting is reached through the configuration strobe and then switched back, so that both flag sequences and the memory contents are compared under each setting.

// File: rtl/wt_wbuf_pkg.sv
package wt_wbuf_pkg;
   typedef enum logic {
      SRC_SLOT = 1'b0,
      SRC_CPU  = 1'b1
   } wb_src_e;
endpackage

// File: rtl/wt_wbuf_slot.sv
module wt_wbuf_slot #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter bit HAS_BE = 1'b1,
   localparam int BE_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              take,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic [BE_W-1:0]   in_be,
   output logic              valid,
   output logic [ADDR_W-1:0] q_addr,
   output logic [DATA_W-1:0] q_data,
   output logic [BE_W-1:0]   q_be
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
      end else if (take) begin
         valid <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (load) begin
         q_addr <= in_addr;
         q_data <= in_data;
      end
   end

   generate
      if (HAS_BE) begin : g_be
         always_ff @(posedge clk) begin
            if (load) q_be <= in_be;
         end
      end else begin : g_full
         logic unused_be;
         assign unused_be = ^in_be;
         assign q_be = '1;
      end
   endgenerate

   AST_SLOT_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !valid); // R8
   AST_SLOT_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> valid); // R5
endmodule

// File: rtl/wt_wbuf_extport.sv
module wt_wbuf_extport
   import wt_wbuf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int BE_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  wb_src_e           src,
   input  logic [ADDR_W-1:0] slot_addr,
   input  logic [DATA_W-1:0] slot_data,
   input  logic [BE_W-1:0]   slot_be,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic [BE_W-1:0]   cpu_be,
   input  logic              ext_ack,
   output logic              ext_req,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_wdata,
   output logic [BE_W-1:0]   ext_be,
   output wb_src_e           cur_src,
   output logic              complete
);
   assign complete = ext_req && ext_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_req <= 1'b0;
         cur_src <= SRC_SLOT;
      end else if (launch) begin
         ext_req <= 1'b1;
         cur_src <= src;
      end else if (complete) begin
         ext_req <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (launch) begin
         ext_addr  <= (src == SRC_CPU) ? cpu_addr : slot_addr;
         ext_wdata <= (src == SRC_CPU) ? cpu_data : slot_data;
         ext_be    <= (src == SRC_CPU) ? cpu_be   : slot_be;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req && !ext_ack |=> ext_req && $stable(ext_addr) && $stable(ext_wdata) && $stable(ext_be)); // R7
   AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !ext_req); // R5
endmodule

// File: rtl/wt_wbuf_flags.sv
module wt_wbuf_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic take,
   input  logic launch,
   input  logic complete,
   output logic flag_empty,
   output logic flag_done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_empty <= 1'b1;
      end else if (take) begin
         flag_empty <= 1'b1;
      end else if (load) begin
         flag_empty <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_done <= 1'b1;
      end else if (launch) begin
         flag_done <= 1'b0;
      end else if (complete) begin
         flag_done <= 1'b1;
      end
   end

   AST_EMPTY_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_empty) |-> $fell(flag_done)); // R5
endmodule

// File: rtl/wt_wbuf.sv
module wt_wbuf
   import wt_wbuf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter bit HAS_BE = 1'b1,
   localparam int BE_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_en_d,
   input  logic              cpu_wr_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [BE_W-1:0]   cpu_be,
   input  logic              cpu_hit,
   output logic              cpu_stall,
   output logic              cache_we,
   output logic [ADDR_W-1:0] cache_addr,
   output logic [DATA_W-1:0] cache_wdata,
   output logic [BE_W-1:0]   cache_be,
   output logic              lru_upd,
   output logic              ext_req,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_wdata,
   output logic [BE_W-1:0]   ext_be,
   input  logic              ext_ack,
   output logic              flag_empty,
   output logic              flag_done
);
   initial begin : elab_chk
      if (DATA_W % 8 != 0 || DATA_W < 8) $fatal(1, "wt_wbuf: DATA_W must be a multiple of 8");
      if (ADDR_W < 2) $fatal(1, "wt_wbuf: ADDR_W too small");
   end

   logic              buf_en_q;
   logic              slot_valid;
   logic [ADDR_W-1:0] slot_addr;
   logic [DATA_W-1:0] slot_data;
   logic [BE_W-1:0]   slot_be;
   logic              slot_take, slot_load, direct_go, launch, complete;
   logic              direct_pend, accept;
   wb_src_e           launch_src, cur_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_en_q <= 1'b1;
      else if (cfg_we) buf_en_q <= cfg_en_d;
   end

   assign direct_pend = ext_req && (cur_src == SRC_CPU);
   assign slot_take   = slot_valid && !ext_req;
   assign direct_go   = cpu_wr_req && !buf_en_q && !slot_valid && !ext_req;
   assign launch      = slot_take || direct_go;
   assign launch_src  = slot_take ? SRC_SLOT : SRC_CPU;

   always_comb begin
      if (!cpu_wr_req)      cpu_stall = 1'b0;
      else if (direct_pend) cpu_stall = !ext_ack;
      else if (buf_en_q)    cpu_stall = slot_valid;
      else                  cpu_stall = 1'b1;
   end

   assign accept    = cpu_wr_req && !cpu_stall;
   assign slot_load = accept && buf_en_q && !direct_pend;

   assign cache_we    = accept && cpu_hit;
   assign lru_upd     = accept && cpu_hit;
   assign cache_addr  = cpu_addr;
   assign cache_wdata = cpu_wdata;
   assign cache_be    = cpu_be;

   wt_wbuf_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_BE(HAS_BE)) slot_i (
      .clk(clk), .rst_n(rst_n), .load(slot_load), .take(slot_take),
      .in_addr(cpu_addr), .in_data(cpu_wdata), .in_be(cpu_be),
      .valid(slot_valid), .q_addr(slot_addr), .q_data(slot_data), .q_be(slot_be)
   );

   wt_wbuf_extport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
      .clk(clk), .rst_n(rst_n), .launch(launch), .src(launch_src),
      .slot_addr(slot_addr), .slot_data(slot_data), .slot_be(slot_be),
      .cpu_addr(cpu_addr), .cpu_data(cpu_wdata), .cpu_be(cpu_be),
      .ext_ack(ext_ack), .ext_req(ext_req), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .ext_be(ext_be), .cur_src(cur_src), .complete(complete)
   );

   wt_wbuf_flags flags_i (
      .clk(clk), .rst_n(rst_n), .load(slot_load), .take(slot_take),
      .launch(launch), .complete(complete),
      .flag_empty(flag_empty), .flag_done(flag_done)
   );

   AST_DIRECT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr_req && !buf_en_q && !ext_req |-> cpu_stall); // R9
   AST_DONE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_done) |-> $past(ext_req && ext_ack)); // R6
   AST_EMPTY_TRACKS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      flag_empty == !slot_valid); // R4
   AST_DIRECT_KEEPS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      direct_pend |-> flag_empty); // R9
endmodule

// File: tb/wt_wbuf_tb_top.sv
`timescale 1ns/1ps
module wt_wbuf_tb_top;
   localparam int AW = 32, DW = 32, BW = DW / 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0, cfg_en_d = 1'b1;
   logic cpu_wr_req = 1'b0, cpu_hit = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [BW-1:0] cpu_be = '0;
   logic cpu_stall, cache_we, lru_upd, ext_req, ext_ack = 1'b0, flag_empty, flag_done;
   logic [AW-1:0] cache_addr, ext_addr;
   logic [DW-1:0] cache_wdata, ext_wdata;
   logic [BW-1:0] cache_be, ext_be;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [DW-1:0] mem [16];
   logic [DW-1:0] exp_mem [16];

   always #2.5 clk = ~clk;

   wt_wbuf dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en_d(cfg_en_d),
      .cpu_wr_req(cpu_wr_req), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_be(cpu_be), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
      .cache_we(cache_we), .cache_addr(cache_addr), .cache_wdata(cache_wdata),
      .cache_be(cache_be), .lru_upd(lru_upd), .ext_req(ext_req),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_be(ext_be),
      .ext_ack(ext_ack), .flag_empty(flag_empty), .flag_done(flag_done)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model: random acknowledge delay of 0..3 cycles
   int ack_cnt = 0;
   always @(negedge clk) begin
      if (ext_ack) ext_ack = 1'b0;
      else if (rst_n && ext_req) begin
         if (ack_cnt == 0) begin
            ext_ack = 1'b1;
            ack_cnt = $urandom_range(3, 0);
         end else ack_cnt--;
      end
   end

   always @(posedge clk) begin
      if (rst_n && ext_req && ext_ack)
         for (int b = 0; b < BW; b++)
            if (ext_be[b]) mem[ext_addr[5:2]][8*b +: 8] <= ext_wdata[8*b +: 8];
   end

   // request stability monitor
   logic p_req = 1'b0, p_ack = 1'b0;
   logic [AW-1:0] p_addr;
   logic [DW-1:0] p_data;
   logic [BW-1:0] p_be;
   always @(negedge clk) begin
      #2;
      if (rst_n && p_req && !p_ack)
         chk(ext_req && ext_addr == p_addr && ext_wdata == p_data && ext_be == p_be,
             "R7 request held until ack", {ext_req, ext_wdata}, {1'b1, p_data});
      p_req = ext_req; p_ack = ext_ack; p_addr = ext_addr; p_data = ext_wdata; p_be = ext_be;
   end

   // one processor write; called just after a negedge, returns just after a negedge
   task automatic cpu_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be,
                            input logic hit, output int stalls, output bit empty_all);
      cpu_wr_req = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_hit = hit;
      stalls = 0; empty_all = 1'b1;
      #1;
      while (cpu_stall && stalls < 40) begin
         empty_all &= flag_empty;
         stalls++;
         @(negedge clk); #1;
      end
      if (hit) chk(cache_we && lru_upd && cache_addr == a && cache_wdata == d && cache_be == be,
                   "R2 hit writes cache and updates LRU", {cache_we, lru_upd, cache_wdata}, {2'b11, d});
      else     chk(!cache_we && !lru_upd, "R3 miss leaves cache and LRU alone",
                   {cache_we, lru_upd}, 2'b00);
      for (int b = 0; b < BW; b++) if (be[b]) exp_mem[a[5:2]][8*b +: 8] = d[8*b +: 8];
      @(posedge clk); @(negedge clk);
      cpu_wr_req = 1'b0; cpu_hit = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 40; i++) begin
         if (!ext_req && flag_empty && flag_done) break;
         @(negedge clk); #1;
      end
   endtask

   task automatic check_mem(input logic [AW-1:0] a, input string req);
      chk(mem[a[5:2]] == exp_mem[a[5:2]], req, mem[a[5:2]], exp_mem[a[5:2]]);
   endtask

   task automatic set_cfg(input logic en);
      cfg_we = 1'b1; cfg_en_d = en;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk(flag_empty && flag_done, "R1 flags after reset", {flag_empty, flag_done}, 2'b11);
      chk(!ext_req && !cpu_stall, "R1 idle outputs after reset", {ext_req, cpu_stall}, 2'b00);
      @(negedge clk);
   endtask

   task automatic t_buf_hit();
      int st; bit ea;
      cpu_write(32'h04, 32'hA1B2C3D4, 4'hF, 1'b1, st, ea);
      chk(st == 0, "R4 buffered write accepted without stall", st, 0);
      #1;
      chk(!flag_empty && flag_done, "R4 slot full after accept", {flag_empty, flag_done}, 2'b01);
      @(negedge clk); #1;
      chk(ext_req && flag_empty && !flag_done && ext_addr == 32'h04 && ext_wdata == 32'hA1B2C3D4,
          "R5 drain raises request and swaps flags", {ext_req, flag_empty, flag_done, ext_wdata},
          {3'b110, 32'hA1B2C3D4});
      for (int i = 0; i < 10 && !flag_done; i++) begin @(negedge clk); #1; end
      chk(flag_done && !ext_req, "R6 ack completes write", {flag_done, ext_req}, 2'b10);
      check_mem(32'h04, "R11 buffered hit data in memory");
      @(negedge clk);
   endtask

   task automatic t_buf_miss();
      int st; bit ea;
      cpu_write(32'h08, 32'h0BADF00D, 4'hF, 1'b0, st, ea);
      chk(st == 0, "R4 miss write accepted without stall", st, 0);
      wait_idle();
      check_mem(32'h08, "R3 miss still reaches memory");
      @(negedge clk);
   endtask

   task automatic t_full_stall();
      int st; bit ea;
      cpu_write(32'h10, 32'h11111111, 4'hF, 1'b1, st, ea);
      cpu_write(32'h14, 32'h22222222, 4'hF, 1'b0, st, ea);
      chk(st == 1, "R8 write after fill stalls one cycle", st, 1);
      cpu_write(32'h18, 32'h33333333, 4'hF, 1'b1, st, ea);
      chk(st >= 1, "R8 write to full slot behind busy port stalls", st, 1);
      wait_idle();
      check_mem(32'h10, "R8 first queued word");
      check_mem(32'h14, "R8 second queued word");
      check_mem(32'h18, "R8 third queued word");
      @(negedge clk);
   endtask

   task automatic t_direct();
      int st; bit ea;
      set_cfg(1'b0);
      #1;
      chk(!ext_req && !cpu_stall, "R10 config write leaves port idle", {ext_req, cpu_stall}, 2'b00);
      @(negedge clk);
      cpu_write(32'h20, 32'hCAFEBABE, 4'hF, 1'b1, st, ea);
      chk(st >= 1, "R9 direct write stalls until ack", st, 1);
      chk(ea, "R9 empty flag stays high in direct mode", ea, 1);
      #1;
      chk(flag_done && !ext_req && flag_empty, "R9 stall ends with write complete",
          {flag_done, ext_req, flag_empty}, 3'b101);
      check_mem(32'h20, "R9 memory written when stall ends");
      @(negedge clk);
      cpu_write(32'h24, 32'h5A5A5A5A, 4'hF, 1'b0, st, ea);
      chk(st >= 1 && ea, "R9 direct miss stalls with slot empty", {st[7:0], ea}, 9'h3);
      check_mem(32'h24, "R3 direct miss reaches memory");
      @(negedge clk);
   endtask

   task automatic t_bytes();
      int st; bit ea;
      cpu_write(32'h28, 32'hFFFFFFFF, 4'hF, 1'b1, st, ea);
      cpu_write(32'h28, 32'h00AB0012, 4'b0101, 1'b1, st, ea);
      wait_idle();
      check_mem(32'h28, "R11 partial byte enables merge");
      chk(mem[10] == 32'hFFABFF12, "R11 lane values", mem[10], 32'hFFABFF12);
      @(negedge clk);
   endtask

   task automatic t_reenable();
      int st; bit ea;
      set_cfg(1'b1);
      cpu_write(32'h2C, 32'h600DD00D, 4'hF, 1'b0, st, ea);
      chk(st == 0, "R10 buffered mode restored", st, 0);
      #1;
      chk(!flag_empty, "R10 slot used again", flag_empty, 0);
      wait_idle();
      check_mem(32'h2C, "R10 re-enabled write reaches memory");
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin mem[i] = '0; exp_mem[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_buf_hit();
      t_buf_miss();
      t_full_stall();
      t_direct();
      t_bytes();
      t_reenable();
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule